// File: doc/BRIEF.md
# User-Timer Deadline Event Unit

This unit holds one 64-bit timer word. The low six bits of the word are an interrupt vector. The remaining upper bits are a deadline, and the deadline's low six bits are always zero. The unit compares the deadline, unsigned and across the full width, against a free-running timestamp counter that arrives as an input. It flags an event as pending while the deadline is non-zero and the counter has reached it.

A pending event is taken only on an instruction-boundary strobe, and only when the core-state qualifier inputs allow it. When the event is taken, the unit sends a one-cycle set request to the user-interrupt request register. The request carries the vector as an index and as a one-hot mask. The unit also signals that a user interrupt is recognised, and it clears the whole timer word, vector and deadline together.

While the core is asleep in a timed pause or a monitor wait, an event that is ready raises a wake output so that the core can reach a boundary. In the cycle the timer event is taken, it blocks any user-interrupt delivery request. A software write arriving in that same cycle overrides it.

Top module: `utimer_event_unit`

## Requirements
- R1: A write (`wr_en`=1) stores `wr_data` whole. From the next cycle on, `rd_data` returns it: bits 5:0 are the vector, bits 63:6 are the deadline, and no bit is reserved.
- R2: `pend` is 1 exactly when the deadline (`rd_data` with bits 5:0 cleared) is non-zero and `tsc` is greater than or equal to it, compared unsigned over all 64 bits. It follows `tsc` in the same cycle.
- R3: A write whose bits 63:6 are zero leaves `pend` at 0 from the next cycle, whatever the vector bits are and whatever `tsc` is.
- R4: An event is taken only when all of the following hold in the same cycle: `pend`=1, `boundary`=1, `feat_en`=1, `long_mode`=1, `cs_long`=1, `priv_lvl`=3, `uif`=1, `in_shutdown`=0, `in_wait_startup`=0.
- R5: In the cycle after an event is taken, `uirr_set` and `uint_recog` are 1 for exactly one cycle. In that cycle `uirr_idx` holds the vector and `uirr_onehot` has only bit [vector] set.
- R6: In the cycle after an event is taken, `rd_data` is zero and `pend` is 0.
- R7: `wake` equals `pend` AND `in_sleep` AND every core-state qualifier of R4. It is combinational and does not need `boundary`.
- R8: `deliver_grant` follows `deliver_req`, except in a cycle where a timer event is taken, when it is 0.
- R9: A write in the same cycle as a qualified boundary wins. No event is taken, and the written value is stored.
- R10: With `boundary`=0 no event is taken. The timer word and `pend` stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Timer word write strobe |
| wr_data | input | 64 | Value to write |
| rd_data | output | 64 | Current timer word |
| tsc | input | 64 | Timestamp counter value |
| boundary | input | 1 | Instruction-boundary strobe |
| feat_en | input | 1 | Feature enable |
| long_mode | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment is 64-bit |
| priv_lvl | input | 2 | Current privilege level |
| uif | input | 1 | User-interrupt flag |
| in_shutdown | input | 1 | Core in shutdown state |
| in_wait_startup | input | 1 | Core waiting for startup message |
| in_sleep | input | 1 | Core in timed-pause or monitor-wait sleep |
| deliver_req | input | 1 | User-interrupt delivery request |
| deliver_grant | output | 1 | Delivery allowed this cycle |
| pend | output | 1 | Timer event pending |
| wake | output | 1 | Wake request to a sleeping core |
| uirr_set | output | 1 | Request-register set pulse |
| uirr_idx | output | 6 | Bit index to set |
| uirr_onehot | output | 64 | One-hot set mask |
| uint_recog | output | 1 | User interrupt recognised pulse |

## Verification
The outputs fall into two timing groups.

- **Combinational:** `pend`, `wake` and `deliver_grant` react in the same cycle as their inputs. The bench samples them one time step after it drives the inputs on a falling edge.
- **One register deep:** a write, and the set and recognise outputs after a taken event, appear one rising edge later. The bench samples these at the next falling edge. It samples once more a cycle later to confirm that the pulse has ended.

Every expected value comes from the bench's own deadline arithmetic.

// File: rtl/utev_pkg.sv
package utev_pkg;

  localparam int TSC_W_DEF = 64;
  localparam int VEC_W_DEF = 6;
  localparam int PL_W_DEF  = 2;

  typedef struct packed {
    logic                feat_en;
    logic                long_mode;
    logic                cs_long;
    logic [PL_W_DEF-1:0] priv;
    logic                uif;
    logic                shutdown;
    logic                wait_startup;
  } core_state_t;

  // deadline part of the timer word: vector bits forced to zero
  function automatic logic [TSC_W_DEF-1:0] deadline_of(input logic [TSC_W_DEF-1:0] w);
    logic [TSC_W_DEF-1:0] m;
    m = '1;
    m[VEC_W_DEF-1:0] = '0;
    return w & m;
  endfunction

  function automatic logic [VEC_W_DEF-1:0] vector_of(input logic [TSC_W_DEF-1:0] w);
    return w[VEC_W_DEF-1:0];
  endfunction

  // unsigned full-width deadline test, zero deadline disables
  function automatic logic deadline_hit(input logic [TSC_W_DEF-1:0] dl,
                                        input logic [TSC_W_DEF-1:0] t);
    return (dl != '0) && (t >= dl);
  endfunction

  function automatic logic state_allows(input core_state_t s,
                                        input logic [PL_W_DEF-1:0] user_pl);
    return s.feat_en && s.long_mode && s.cs_long && (s.priv == user_pl) &&
           s.uif && !s.shutdown && !s.wait_startup;
  endfunction

endpackage

// File: rtl/utev_timer_reg.sv
module utev_timer_reg #(
  parameter int TSC_W = utev_pkg::TSC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TSC_W-1:0] wr_data,
  input  logic             clr,
  output logic [TSC_W-1:0] word_q
);
  // software write has precedence over the self-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wr_data;
    else if (clr)   word_q <= '0;
  end
endmodule

// File: rtl/utev_deadline_cmp.sv
module utev_deadline_cmp #(
  parameter int TSC_W = utev_pkg::TSC_W_DEF
) (
  input  logic [TSC_W-1:0] word,
  input  logic [TSC_W-1:0] tsc,
  output logic             pend
);
  import utev_pkg::*;
  logic [TSC_W-1:0] dl;
  always_comb begin
    dl   = deadline_of(word);
    pend = deadline_hit(dl, tsc);
  end
endmodule

// File: rtl/utev_qualify.sv
module utev_qualify #(
  parameter int                          PL_W    = utev_pkg::PL_W_DEF,
  parameter logic [utev_pkg::PL_W_DEF-1:0] USER_PL = 2'd3
) (
  input  utev_pkg::core_state_t state,
  input  logic                  pend,
  input  logic                  boundary,
  input  logic                  wr_en,
  input  logic                  in_sleep,
  input  logic                  deliver_req,
  output logic                  qual_ok,
  output logic                  fire,
  output logic                  wake,
  output logic                  deliver_grant
);
  import utev_pkg::*;
  always_comb begin
    qual_ok       = state_allows(state, USER_PL);
    fire          = pend && qual_ok && boundary && !wr_en;
    wake          = pend && qual_ok && in_sleep;
    deliver_grant = deliver_req && !fire;
  end
endmodule

// File: rtl/utev_req_out.sv
module utev_req_out #(
  parameter int VEC_W = utev_pkg::VEC_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic [VEC_W-1:0]        vec,
  output logic                    set_q,
  output logic                    recog_q,
  output logic [VEC_W-1:0]        idx_q,
  output logic [(1<<VEC_W)-1:0]   onehot
);
  localparam int UIRR_W = 1 << VEC_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q   <= 1'b0;
      recog_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      set_q   <= fire;
      recog_q <= fire;
      if (fire) idx_q <= vec;
    end
  end

  for (genvar i = 0; i < UIRR_W; i++) begin : g_bit
    assign onehot[i] = set_q && (idx_q == VEC_W'(i));
  end
endmodule

// File: rtl/utimer_event_unit.sv
module utimer_event_unit #(
  parameter int TSC_W = utev_pkg::TSC_W_DEF,
  parameter int VEC_W = utev_pkg::VEC_W_DEF,
  parameter int PL_W  = utev_pkg::PL_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [TSC_W-1:0]      wr_data,
  output logic [TSC_W-1:0]      rd_data,
  input  logic [TSC_W-1:0]      tsc,
  input  logic                  boundary,
  input  logic                  feat_en,
  input  logic                  long_mode,
  input  logic                  cs_long,
  input  logic [PL_W-1:0]       priv_lvl,
  input  logic                  uif,
  input  logic                  in_shutdown,
  input  logic                  in_wait_startup,
  input  logic                  in_sleep,
  input  logic                  deliver_req,
  output logic                  deliver_grant,
  output logic                  pend,
  output logic                  wake,
  output logic                  uirr_set,
  output logic [VEC_W-1:0]      uirr_idx,
  output logic [(1<<VEC_W)-1:0] uirr_onehot,
  output logic                  uint_recog
);
  import utev_pkg::*;

  logic [TSC_W-1:0] word_q;
  logic             evt_pend;
  logic             evt_qual;
  logic             evt_fire;
  logic [VEC_W-1:0] cur_vec;
  core_state_t      cstate;

  always_comb begin
    cstate.feat_en      = feat_en;
    cstate.long_mode    = long_mode;
    cstate.cs_long      = cs_long;
    cstate.priv         = priv_lvl;
    cstate.uif          = uif;
    cstate.shutdown     = in_shutdown;
    cstate.wait_startup = in_wait_startup;
    cur_vec             = vector_of(word_q);
  end

  utev_timer_reg #(.TSC_W(TSC_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .clr(evt_fire), .word_q(word_q)
  );

  utev_deadline_cmp #(.TSC_W(TSC_W)) u_cmp (
    .word(word_q), .tsc(tsc), .pend(evt_pend)
  );

  utev_qualify #(.PL_W(PL_W)) u_qual (
    .state(cstate), .pend(evt_pend), .boundary(boundary), .wr_en(wr_en),
    .in_sleep(in_sleep), .deliver_req(deliver_req), .qual_ok(evt_qual),
    .fire(evt_fire), .wake(wake), .deliver_grant(deliver_grant)
  );

  utev_req_out #(.VEC_W(VEC_W)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(evt_fire), .vec(cur_vec),
    .set_q(uirr_set), .recog_q(uint_recog), .idx_q(uirr_idx),
    .onehot(uirr_onehot)
  );

  assign rd_data = word_q;
  assign pend    = evt_pend;
endmodule

// File: rtl/utev_checker.sv
module utev_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [63:0] wr_data,
  input logic [63:0] rd_data,
  input logic        pend,
  input logic        wake,
  input logic        fire,
  input logic        uirr_set,
  input logic [5:0]  uirr_idx,
  input logic        deliver_grant,
  input logic        feat_en,
  input logic [1:0]  priv_lvl,
  input logic        uif
);
  assert_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  assert_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[63:6] == 58'd0) |=> !pend);

  assert_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (feat_en && priv_lvl == 2'd3 && uif && pend));

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    uirr_set |=> !uirr_set);

  assert_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> uirr_idx == $past(rd_data[5:0]));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (rd_data == 64'd0 && !pend));

  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> pend);

  assert_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_grant |=> !uirr_set);

  assert_wr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !fire);
endmodule

bind utimer_event_unit utev_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pend(pend), .wake(wake), .fire(evt_fire),
  .uirr_set(uirr_set), .uirr_idx(uirr_idx), .deliver_grant(deliver_grant),
  .feat_en(feat_en), .priv_lvl(priv_lvl), .uif(uif)
);

// File: tb/utimer_event_unit_bench.sv
module utimer_event_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [63:0] tsc = '0;
  logic        boundary = 1'b0;
  logic        feat_en = 1'b0, long_mode = 1'b0, cs_long = 1'b0;
  logic [1:0]  priv_lvl = 2'd0;
  logic        uif = 1'b0, in_shutdown = 1'b0, in_wait_startup = 1'b0;
  logic        in_sleep = 1'b0, deliver_req = 1'b0;
  logic        deliver_grant, pend, wake, uirr_set, uint_recog;
  logic [5:0]  uirr_idx;
  logic [63:0] uirr_onehot;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  utimer_event_unit u_utimer_event_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tsc(tsc), .boundary(boundary), .feat_en(feat_en),
    .long_mode(long_mode), .cs_long(cs_long), .priv_lvl(priv_lvl), .uif(uif),
    .in_shutdown(in_shutdown), .in_wait_startup(in_wait_startup),
    .in_sleep(in_sleep), .deliver_req(deliver_req),
    .deliver_grant(deliver_grant), .pend(pend), .wake(wake),
    .uirr_set(uirr_set), .uirr_idx(uirr_idx), .uirr_onehot(uirr_onehot),
    .uint_recog(uint_recog)
  );

  // qualifier byte: {feat, long, cs_long, priv[1:0], uif, shutdown, wait_startup}
  localparam logic [7:0] QOK = 8'hFC;

  typedef struct packed {
    logic [63:0] wdata;
    logic [63:0] t;
    logic [7:0]  qual;
    logic        bnd;
    logic        exp_fire;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{64'h0000_0000_0000_1005, 64'h0000_0000_0000_1000, QOK,   1'b1, 1'b1},
    '{64'h0000_0000_0000_2027, 64'h0000_0000_0000_1FFF, QOK,   1'b1, 1'b0},
    '{64'h0000_0000_0000_003F, 64'hFFFF_FFFF_FFFF_FFFF, QOK,   1'b1, 1'b0},
    '{64'h8000_0000_0000_0040, 64'h8000_0000_0000_0041, QOK,   1'b1, 1'b1},
    '{64'h0000_0000_0000_0101, 64'h0000_0000_0000_0200, 8'hF4, 1'b1, 1'b0},
    '{64'h0000_0000_0000_0101, 64'h0000_0000_0000_0200, 8'hF8, 1'b1, 1'b0},
    '{64'h0000_0000_0000_0101, 64'h0000_0000_0000_0200, 8'h7C, 1'b1, 1'b0},
    '{64'h0000_0000_0000_0101, 64'h0000_0000_0000_0200, 8'hFE, 1'b1, 1'b0},
    '{64'h0000_0000_0000_0101, 64'h0000_0000_0000_0200, 8'hFD, 1'b1, 1'b0},
    '{64'h0000_0000_0000_0101, 64'h0000_0000_0000_0200, 8'hDC, 1'b1, 1'b0},
    '{64'h0000_0000_0000_0101, 64'h0000_0000_0000_0200, 8'hBC, 1'b1, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, QOK,   1'b1, 1'b1},
    '{64'h0000_0000_0000_0A0C, 64'h0000_0000_0000_0B00, QOK,   1'b0, 1'b0},
    '{64'h7FFF_FFFF_FFFF_FFC9, 64'h8000_0000_0000_0000, QOK,   1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_qual(input logic [7:0] q);
    {feat_en, long_mode, cs_long, priv_lvl, uif, in_shutdown, in_wait_startup} = q;
  endtask

  function automatic logic model_pend(input logic [63:0] w, input logic [63:0] t);
    logic [63:0] dl;
    dl = {w[63:6], 6'd0};
    return (dl != 64'd0) && !(t < dl);
  endfunction

  task automatic write_word(input logic [63:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state
    chk(rd_data == 64'd0, "R1 reset word", rd_data, 64'd0);
    chk(!pend && !wake && !uirr_set && !uint_recog, "R2 reset outputs",
        {60'd0, pend, wake, uirr_set, uint_recog}, 64'd0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic ep;
      logic [5:0] v;
      tsc = TBL[i].t;
      set_qual(8'h00);
      write_word(TBL[i].wdata);
      ep = model_pend(TBL[i].wdata, TBL[i].t);
      v  = TBL[i].wdata[5:0];
      chk(rd_data == TBL[i].wdata, "R1 read back", rd_data, TBL[i].wdata);
      chk(pend == ep, "R2 pending compare", {63'd0, pend}, {63'd0, ep});
      set_qual(TBL[i].qual);
      boundary = TBL[i].bnd;
      deliver_req = 1'b1;
      #1;
      chk(deliver_grant == !TBL[i].exp_fire, "R8 grant priority",
          {63'd0, deliver_grant}, {63'd0, !TBL[i].exp_fire});
      @(negedge clk);
      boundary = 1'b0; deliver_req = 1'b0; set_qual(8'h00);
      #1;
      if (TBL[i].bnd == 1'b0)
        chk(!uirr_set && rd_data == TBL[i].wdata && pend == ep, "R10 no strobe",
            rd_data, TBL[i].wdata);
      else
        chk(uirr_set == TBL[i].exp_fire && uint_recog == TBL[i].exp_fire,
            "R4 take gating", {63'd0, uirr_set}, {63'd0, TBL[i].exp_fire});
      if (TBL[i].exp_fire) begin
        chk(uirr_idx == v, "R5 index", {58'd0, uirr_idx}, {58'd0, v});
        chk(uirr_onehot == (64'd1 << v), "R5 onehot", uirr_onehot, 64'd1 << v);
        chk(rd_data == 64'd0 && !pend, "R6 self clear", rd_data, 64'd0);
      end else begin
        chk(uirr_onehot == 64'd0, "R5 no mask", uirr_onehot, 64'd0);
        chk(rd_data == TBL[i].wdata, "R10 word kept", rd_data, TBL[i].wdata);
      end
      @(negedge clk);
      #1;
      chk(!uirr_set && !uint_recog, "R5 single pulse", {63'd0, uirr_set}, 64'd0);
    end

    // R3: zero deadline with nonzero vector cancels a pending event
    tsc = 64'h3000;
    write_word(64'h2000);
    chk(pend == 1'b1, "R2 pending set", {63'd0, pend}, 64'd1);
    write_word(64'h15);
    chk(!pend && rd_data == 64'h15, "R3 cancel", rd_data, 64'h15);

    // R2: same-cycle response to tsc crossing the deadline
    write_word(64'h5008);
    tsc = 64'h4FFF; #1;
    chk(!pend, "R2 below deadline", {63'd0, pend}, 64'd0);
    tsc = 64'h5000; #1;
    chk(pend, "R2 at deadline", {63'd0, pend}, 64'd1);

    // R7: wake needs pending, sleep and qualifiers, not a boundary
    set_qual(QOK); in_sleep = 1'b1; #1;
    chk(wake, "R7 wake asserted", {63'd0, wake}, 64'd1);
    in_sleep = 1'b0; #1;
    chk(!wake, "R7 awake core", {63'd0, wake}, 64'd0);
    in_sleep = 1'b1; priv_lvl = 2'd0; #1;
    chk(!wake, "R7 kernel level", {63'd0, wake}, 64'd0);
    in_sleep = 1'b0; set_qual(8'h00);
    @(negedge clk);

    // R9: write coinciding with a qualified boundary wins
    tsc = 64'h2000;
    write_word(64'h1003);
    set_qual(QOK); boundary = 1'b1; wr_en = 1'b1; wr_data = 64'h6008;
    @(negedge clk);
    wr_en = 1'b0; boundary = 1'b0; set_qual(8'h00);
    #1;
    chk(!uirr_set, "R9 no event on write", {63'd0, uirr_set}, 64'd0);
    chk(rd_data == 64'h6008 && !pend, "R9 write stored", rd_data, 64'h6008);

    finish_run();
  end
endmodule